// File: doc/BRIEF.md
# PCIe Transmit Credit Gate

This block sits on the application side of a PCIe transmit path. It decides, one request at a time, whether a TLP of a given traffic class and payload size may be launched without overrunning the link partner's flow-control buffers. The core exposes its credit limits through a single multiplexed read port. The caller picks a class with a select, and the header and data limits for that class appear a fixed two clocks later. The gate drives that select itself. It steps through posted, non-posted and completion and holds each class for three cycles. It keeps the limit only from the last cycle of each hold, so a cached limit is never more than nine cycles old.

The gate also tracks consumption for all six credit types: posted, non-posted and completion, each with a header and a data counter. Two sources feed these counters. One is the credits that the application's own launches use. The other is the one-cycle pulses the core raises when it spends credits for traffic it generates itself. For each type, the available count is the limit minus the consumed count, taken modulo the counter width. A type flagged as infinite is never checked. Until data-link-up is asserted the gate grants nothing. A drop of link-up clears all counters and all cached limits.

Requests arrive on a valid/ready interface. `req_ready` is a combinational function of the current request fields, the cached limits and the counters. A launch happens on a cycle where `req_valid` and `req_ready` are both high. While `req_valid` is high and `req_ready` is low, the requester must hold the class and byte count stable. Nothing is consumed on such a cycle.

Top module: `tx_credit_gate`

## Requirements
- R1: While `link_up` is low, `req_ready` is 0. One clock after `link_up` is seen low, every consumed counter is zero and every cached limit is marked invalid.
- R2: Out of reset `lim_sel` is 0. It then steps 0,1,2,0,… and holds each value for exactly three cycles. It never takes the value 3.
- R3: A class's limit is captured on the clock edge that ends the third cycle of its hold. That is two cycles after the select changed, so values shown earlier in the hold are never used.
- R4: After `link_up` rises, a class grants nothing until its limit has been captured with `link_up` high. This takes at most nine cycles.
- R5: Every TLP needs one header credit and ceil(`req_bytes`/16) data credits. A request with zero bytes needs no data credit.
- R6: `req_ready` is 1 only when, for both the header and the data type of the requested class, (limit − consumed) mod 2^width is at least the need. The width is 8 bits for headers and 12 bits for data. Class encodings: 0 posted, 1 non-posted, 2 completion. Class 3 is never granted.
- R7: On a cycle with `req_valid` and `req_ready` both high, the header and data needs are added to that class's consumed counters. A request with `req_valid` high and `req_ready` low consumes nothing.
- R8: Each set bit of `core_cons` adds one credit to its type's consumed counter in that cycle. Bit order from 5 down to 0: posted header, posted data, non-posted header, non-posted data, completion header, completion data. This adds to the application's own consumption in the same cycle.
- R9: When the `inf_flags` bit of a type is set, using the same bit order as R8, that type never blocks a request, whatever its limit and consumed count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Data link up; credit values meaningful only while high |
| lim_sel | output | 2 | Class select driven to the core's limit read port |
| hdr_lim_in | input | HDR_W | Header credit limit for the class selected two cycles earlier |
| dat_lim_in | input | DAT_W | Data credit limit for the class selected two cycles earlier |
| inf_flags | input | 6 | Per-type infinite-credit flags |
| core_cons | input | 6 | Per-type one-cycle consumption pulses from the core |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may launch this cycle |
| req_class | input | 2 | Request traffic class |
| req_bytes | input | BYTES_W | Request payload length in bytes |

## Verification
A consumed counter that is off by even one credit changes `req_ready` only near a boundary. Sweeping the payload size across each class's data limit shows the error as a grant that flips one 16-byte step too early or too late. This is visible on the probe right after the bad update. A limit captured one or two cycles early loads the previous class's values, and a class-wise sweep exposes this within nine cycles of the capture. A select that drifts out of its three-cycle rhythm shows on `lim_sel` in the first round after reset.

// File: rtl/tcg_pkg.sv
package tcg_pkg;

  typedef enum logic [1:0] {
    CLS_POSTED    = 2'd0,
    CLS_NONPOSTED = 2'd1,
    CLS_COMPL     = 2'd2,
    CLS_NONE      = 2'd3
  } cls_e;

  localparam int NUM_CLS   = 3;
  localparam int NUM_TYPES = 2 * NUM_CLS;

  // Bit position of a class's header type in six-bit type vectors.
  function automatic int hdr_bit(input int cls);
    return NUM_TYPES - 1 - 2 * cls;
  endfunction

  // Bit position of a class's data type in six-bit type vectors.
  function automatic int dat_bit(input int cls);
    return NUM_TYPES - 2 - 2 * cls;
  endfunction

  function automatic cls_e next_cls(input cls_e c);
    case (c)
      CLS_POSTED:    return CLS_NONPOSTED;
      CLS_NONPOSTED: return CLS_COMPL;
      default:       return CLS_POSTED;
    endcase
  endfunction

endpackage

// File: rtl/tcg_limit_poller.sv
module tcg_limit_poller
  import tcg_pkg::*;
#(
  parameter int HDR_W = 8,
  parameter int DAT_W = 12,
  parameter int LAT   = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              link_up,
  output logic [1:0]                        lim_sel,
  input  logic [HDR_W-1:0]                  hdr_lim_in,
  input  logic [DAT_W-1:0]                  dat_lim_in,
  output logic [NUM_CLS-1:0][HDR_W-1:0]     hdr_lim,
  output logic [NUM_CLS-1:0][DAT_W-1:0]     dat_lim,
  output logic [NUM_CLS-1:0]                loaded
);

  localparam int DWELL = LAT + 1;
  localparam int PH_W  = (DWELL > 2) ? $clog2(DWELL) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DWELL - 1);

  cls_e            sel_q;
  logic [PH_W-1:0] phase_q;
  logic            cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= CLS_POSTED;
      phase_q <= '0;
    end else if (phase_q == PH_LAST) begin
      sel_q   <= next_cls(sel_q);
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign lim_sel = sel_q;
  // Last cycle of the hold: core output reflects sel_q for LAT cycles.
  assign cap     = (phase_q == PH_LAST);

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    logic hit;
    assign hit = cap && (sel_q == cls_e'(c));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hdr_lim[c] <= '0;
        dat_lim[c] <= '0;
        loaded[c]  <= 1'b0;
      end else if (!link_up) begin
        loaded[c]  <= 1'b0;
      end else if (hit) begin
        hdr_lim[c] <= hdr_lim_in;
        dat_lim[c] <= dat_lim_in;
        loaded[c]  <= 1'b1;
      end
    end
  end

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    lim_sel != 2'b11); // R2

  AST_SEL_DWELL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |=> $stable(sel_q)); // R2

  AST_LOAD_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |=> loaded == '0); // R4

  AST_LOAD_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loaded[0]) |-> $past(sel_q) == CLS_POSTED); // R3

endmodule

// File: rtl/tcg_cons_counter.sv
module tcg_cons_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         core_pulse,
  input  logic [W-1:0] app_add,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else               cnt <= cnt + app_add + W'(core_pulse);
  end

  AST_CLEAR_ON_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0); // R1

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !core_pulse && app_add == '0) |=> $stable(cnt)); // R7

  AST_CORE_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && core_pulse && app_add == '0) |=> cnt == $past(cnt) + W'(1)); // R8

endmodule

// File: rtl/tcg_grant.sv
module tcg_grant
  import tcg_pkg::*;
#(
  parameter int HDR_W   = 8,
  parameter int DAT_W   = 12,
  parameter int BYTES_W = 13,
  parameter int CR_LG   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          link_up,
  input  logic [1:0]                    req_class,
  input  logic [BYTES_W-1:0]            req_bytes,
  input  logic [NUM_TYPES-1:0]          inf_flags,
  input  logic [NUM_CLS-1:0]            loaded,
  input  logic [NUM_CLS-1:0][HDR_W-1:0] hdr_lim,
  input  logic [NUM_CLS-1:0][DAT_W-1:0] dat_lim,
  input  logic [NUM_CLS-1:0][HDR_W-1:0] cons_h,
  input  logic [NUM_CLS-1:0][DAT_W-1:0] cons_d,
  output logic [HDR_W-1:0]              need_h,
  output logic [DAT_W-1:0]              need_d,
  output logic                          ready
);

  localparam int RND_W = BYTES_W + 1;
  localparam logic [RND_W-1:0] ROUND = RND_W'((1 << CR_LG) - 1);

  logic [RND_W-1:0]       rounded;
  logic [NUM_CLS-1:0]     cls_ok;
  logic [NUM_CLS-1:0]     h_room;

  assign rounded = {1'b0, req_bytes} + ROUND;
  assign need_d  = DAT_W'(rounded >> CR_LG);
  assign need_h  = HDR_W'(1);

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    localparam int HB = hdr_bit(c);
    localparam int DB = dat_bit(c);
    logic [HDR_W-1:0] av_h;
    logic [DAT_W-1:0] av_d;
    logic             h_ok, d_ok;

    assign av_h = hdr_lim[c] - cons_h[c];
    assign av_d = dat_lim[c] - cons_d[c];
    assign h_ok = inf_flags[HB] || (av_h >= need_h);
    assign d_ok = inf_flags[DB] || (av_d >= need_d);
    assign cls_ok[c] = loaded[c] && h_ok && d_ok;
    assign h_room[c] = inf_flags[HB] || (av_h != '0);
  end

  always_comb begin
    ready = 1'b0;
    if (link_up && req_class != CLS_NONE)
      ready = cls_ok[req_class];
  end

  AST_NO_GRANT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |-> !ready); // R1

  AST_NO_GRANT_UNLOADED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_class != CLS_NONE && !loaded[req_class]) |-> !ready); // R4

  AST_GRANT_HAS_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req_class != CLS_NONE) |-> h_room[req_class]); // R6

  AST_CLASS3_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_class == CLS_NONE) |-> !ready); // R6

endmodule

// File: rtl/tx_credit_gate.sv
module tx_credit_gate
  import tcg_pkg::*;
#(
  parameter int HDR_W   = 8,
  parameter int DAT_W   = 12,
  parameter int BYTES_W = 13,
  parameter int CR_LG   = 4,
  parameter int LAT     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               link_up,
  output logic [1:0]         lim_sel,
  input  logic [HDR_W-1:0]   hdr_lim_in,
  input  logic [DAT_W-1:0]   dat_lim_in,
  input  logic [5:0]         inf_flags,
  input  logic [5:0]         core_cons,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_class,
  input  logic [BYTES_W-1:0] req_bytes
);

  logic [NUM_CLS-1:0][HDR_W-1:0] hdr_lim, cons_h;
  logic [NUM_CLS-1:0][DAT_W-1:0] dat_lim, cons_d;
  logic [NUM_CLS-1:0]            loaded;
  logic [HDR_W-1:0]              need_h;
  logic [DAT_W-1:0]              need_d;
  logic                          launch;

  tcg_limit_poller #(.HDR_W(HDR_W), .DAT_W(DAT_W), .LAT(LAT)) i_poll (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_up    (link_up),
    .lim_sel    (lim_sel),
    .hdr_lim_in (hdr_lim_in),
    .dat_lim_in (dat_lim_in),
    .hdr_lim    (hdr_lim),
    .dat_lim    (dat_lim),
    .loaded     (loaded)
  );

  tcg_grant #(.HDR_W(HDR_W), .DAT_W(DAT_W), .BYTES_W(BYTES_W), .CR_LG(CR_LG)) i_grant (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_up   (link_up),
    .req_class (req_class),
    .req_bytes (req_bytes),
    .inf_flags (inf_flags),
    .loaded    (loaded),
    .hdr_lim   (hdr_lim),
    .dat_lim   (dat_lim),
    .cons_h    (cons_h),
    .cons_d    (cons_d),
    .need_h    (need_h),
    .need_d    (need_d),
    .ready     (req_ready)
  );

  assign launch = req_valid && req_ready;

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cnt
    logic             mine;
    logic [HDR_W-1:0] add_h;
    logic [DAT_W-1:0] add_d;

    assign mine  = launch && (req_class == cls_e'(c));
    assign add_h = mine ? need_h : '0;
    assign add_d = mine ? need_d : '0;

    tcg_cons_counter #(.W(HDR_W)) i_hdr (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (!link_up),
      .core_pulse (core_cons[hdr_bit(c)]),
      .app_add    (add_h),
      .cnt        (cons_h[c])
    );

    tcg_cons_counter #(.W(DAT_W)) i_dat (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (!link_up),
      .core_pulse (core_cons[dat_bit(c)]),
      .app_add    (add_d),
      .cnt        (cons_d[c])
    );
  end

  AST_CORE_PULSE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    link_up |-> ($onehot0({core_cons[5], core_cons[3], core_cons[1]}) &&
                 ((core_cons & 6'b010101 & ~(core_cons >> 1)) == 6'b0))); // R8

  AST_LAUNCH_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> link_up); // R1

endmodule

// File: tb/test_tx_credit_gate.sv
`timescale 1ns/1ps
module test_tx_credit_gate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_up = 1'b0;
  logic [1:0]  lim_sel;
  logic [7:0]  hdr_lim_in;
  logic [11:0] dat_lim_in;
  logic [5:0]  inf_flags = 6'b0;
  logic [5:0]  core_cons = 6'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_class = 2'd0;
  logic [12:0] req_bytes = 13'd0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  // Core-side model: limits show up two clocks after the select.
  logic [7:0]  hlim [0:3];
  logic [11:0] dlim [0:3];
  logic [1:0]  s1 = 2'd0, s2 = 2'd0;
  always_ff @(posedge clk) begin
    s1 <= lim_sel;
    s2 <= s1;
  end
  assign hdr_lim_in = hlim[s2];
  assign dat_lim_in = dlim[s2];

  // Bench credit model
  logic [7:0]  mch [0:2];
  logic [11:0] mcd [0:2];
  bit          m_loaded = 1'b0;

  tx_credit_gate i_tx_credit_gate (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .lim_sel(lim_sel),
    .hdr_lim_in(hdr_lim_in), .dat_lim_in(dat_lim_in), .inf_flags(inf_flags),
    .core_cons(core_cons), .req_valid(req_valid), .req_ready(req_ready),
    .req_class(req_class), .req_bytes(req_bytes)
  );

  task automatic chk(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_ready(input int c, input int b);
    logic [7:0]  av_h;
    logic [11:0] av_d;
    int          nd;
    if (!link_up || !m_loaded || c > 2) return 1'b0;
    av_h = hlim[c] - mch[c];
    av_d = dlim[c] - mcd[c];
    nd   = (b + 15) / 16;
    return (inf_flags[5-2*c] || av_h >= 8'd1) && (inf_flags[4-2*c] || int'(av_d) >= nd);
  endfunction

  task automatic sweep(input string req);
    for (int c = 0; c < 4; c++) begin
      for (int b = 0; b <= 160; b += ((c == 3) ? 40 : 1)) begin
        @(negedge clk);
        req_class = 2'(c);
        req_bytes = 13'(b);
        #1;
        chk(int'(req_ready), int'(exp_ready(c, b)), req, $sformatf("ready cls %0d bytes %0d", c, b));
      end
    end
  endtask

  task automatic launch(input int c, input int b, input string req);
    bit e;
    @(negedge clk);
    req_class = 2'(c);
    req_bytes = 13'(b);
    req_valid = 1'b1;
    #1;
    e = exp_ready(c, b);
    chk(int'(req_ready), int'(e), req, $sformatf("launch cls %0d bytes %0d", c, b));
    @(posedge clk);
    if (e) begin
      mch[c] = mch[c] + 8'd1;
      mcd[c] = mcd[c] + 12'((b + 15) / 16);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse(input logic [5:0] bits);
    @(negedge clk);
    core_cons = bits;
    @(posedge clk);
    for (int c = 0; c < 3; c++) begin
      mch[c] = mch[c] + 8'(bits[5-2*c]);
      mcd[c] = mcd[c] + 12'(bits[4-2*c]);
    end
    @(negedge clk);
    core_cons = 6'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    hlim[0] = 8'd4; dlim[0] = 12'd5;
    hlim[1] = 8'd2; dlim[1] = 12'd0;
    hlim[2] = 8'd3; dlim[2] = 12'd9;
    hlim[3] = 8'd0; dlim[3] = 12'd0;
    for (int c = 0; c < 3; c++) begin mch[c] = 8'd0; mcd[c] = 12'd0; end

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(int'(req_ready), 0, "R1", "ready in reset");
    chk(int'(lim_sel), 0, "R2", "select in reset");
    rst_n = 1'b1;

    // R2: rotation 0,0,0,1,1,1,2,2,2 twice
    for (int i = 0; i < 18; i++) begin
      chk(int'(lim_sel), (i / 3) % 3, "R2", $sformatf("select step %0d", i));
      @(negedge clk);
    end

    // R1: link down blocks everything
    for (int c = 0; c < 3; c++) begin
      req_class = 2'(c); req_bytes = 13'd0; #1;
      chk(int'(req_ready), 0, "R1", "ready with link down");
    end

    // R4: no grant right after link up
    link_up = 1'b1;
    for (int c = 0; c < 3; c++) begin
      req_class = 2'(c); req_bytes = 13'd0; #1;
      chk(int'(req_ready), 0, "R4", "ready before capture");
    end
    repeat (10) @(posedge clk);
    m_loaded = 1'b1;

    // R3 R5 R6: initial limits, zero consumption
    sweep("R3");

    // R7: launches and a blocked request
    launch(0, 33, "R7");   // need 3 of 5
    launch(0, 40, "R7");   // need 3, 2 left: blocked
    launch(0, 32, "R7");   // need 2 of 2
    launch(1, 0, "R7");
    launch(1, 0, "R7");
    launch(1, 0, "R7");    // header exhausted
    launch(2, 144, "R5");  // need 9 of 9 exactly
    launch(3, 0, "R6");    // class 3 never granted
    sweep("R7");

    // R8: core pulses
    pulse(6'b110000);
    pulse(6'b000010);
    sweep("R8");

    // R9: infinite flags bypass exhausted types
    inf_flags = 6'b001100;
    sweep("R9");
    launch(1, 64, "R9");
    inf_flags = 6'b000001;
    sweep("R9");
    inf_flags = 6'b0;

    // R6: modular availability after posted header counter wraps
    for (int i = 0; i < 254; i++) pulse(6'b100000);
    hlim[0] = mch[0] + 8'd3;
    dlim[0] = mcd[0] + 12'd4;
    repeat (10) @(posedge clk);
    sweep("R6");

    // R1 R4: link drop clears state
    @(negedge clk);
    link_up = 1'b0;
    req_class = 2'd0; req_bytes = 13'd0; #1;
    chk(int'(req_ready), 0, "R1", "ready after link drop");
    repeat (2) @(posedge clk);
    @(negedge clk);
    link_up = 1'b1;
    m_loaded = 1'b0;
    for (int c = 0; c < 3; c++) begin mch[c] = 8'd0; mcd[c] = 12'd0; end
    for (int c = 0; c < 3; c++) begin
      req_class = 2'(c); req_bytes = 13'd0; #1;
      chk(int'(req_ready), 0, "R4", "ready after relink before capture");
    end
    repeat (10) @(posedge clk);
    m_loaded = 1'b1;
    sweep("R1");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule